// File: doc/BRIEF.md
# Four-Mode Self-Test Register

This block is an N-bit register that can take one of four roles in a logic self-test arrangement, picked on every clock by a two-bit mode input. As an ordinary pipeline register it captures its parallel data input. As a scan chain it shifts one bit per clock from a serial input towards a serial output, which lets a test controller seed it or read it out. As a pattern source it runs free as a linear feedback shift register and drives stimulus into the logic that follows it. As a response compactor it works as a multiple-input signature register. In that role it folds the parallel data from the logic ahead of it into a running signature.

Two such registers placed around one block of logic give a self-test pair: one makes the patterns and the other compacts the responses. Swapping their modes then tests the neighbouring block. The feedback polynomial is fixed at 1 + x + x^N. Stage 0 receives the incoming bit, and each clock the contents move one place towards stage N-1.

Top module: `bilbo_reg`

## Requirements
- R1: While the active-low asynchronous reset rst_ni is low, every bit of par_q_o is 0.
- R2: With mode_i = 2'b00 (scan), a rising edge moves bit i-1 into bit i for i = 1..N-1 and loads scan_in_i into bit 0.
- R3: With mode_i = 2'b01 (pattern), a rising edge moves bit i-1 into bit i and loads bit N-1 XOR bit 0 into bit 0, the feedback of the polynomial 1 + x + x^N.
- R4: With mode_i = 2'b10 (normal), a rising edge loads par_d_i into par_q_o, bit for bit.
- R5: With mode_i = 2'b11 (compaction), a rising edge loads (bit N-1 XOR bit 0) XOR par_d_i[0] into bit 0, and bit i-1 XOR par_d_i[i] into bit i for i >= 1.
- R6: scan_out_o equals bit N-1 of par_q_o in every mode.
- R7: N consecutive scan-mode clocks with scan_in_i = 0 leave the register all zeros, whatever it held before.
- R8: A new mode value applies from the first rising edge at which it is present, and it acts on the contents held at that moment. Changing the mode does not by itself alter the contents.
- R9: In pattern mode the value of par_d_i has no effect on the next contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 scan, 01 pattern, 10 normal, 11 compaction |
| par_d_i | input | N | Parallel data or responses to compact |
| par_q_o | output | N | Register contents |
| scan_in_i | input | 1 | Serial input into stage 0 |
| scan_out_o | output | 1 | Serial output, the last stage |

## Verification
Every stage drives par_q_o directly, so a wrong next-state value in any mode shows on the ports one clock after the edge that computed it. The bench compares the full register against its model after every edge. A wrong feedback tap or a dropped data bit in compaction mode stays in the signature for the rest of the run, because later shifts move the error along and later feedback folds it back in rather than clearing it. A fault on the scan path also shows at scan_out_o within N clocks.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

    typedef enum logic [1:0] {
        MODE_SCAN = 2'b00,
        MODE_GEN  = 2'b01,
        MODE_LOAD = 2'b10,
        MODE_SIG  = 2'b11
    } bilbo_mode_e;

    localparam int unsigned NUM_MODES = 4;

    // one-hot select positions
    localparam int unsigned SEL_SCAN = 0;
    localparam int unsigned SEL_GEN  = 1;
    localparam int unsigned SEL_LOAD = 2;
    localparam int unsigned SEL_SIG  = 3;

endpackage

// File: rtl/bilbo_mode_decode.sv
module bilbo_mode_decode
    import bilbo_pkg::*;
(
    input  logic [1:0]           mode_i,
    output logic [NUM_MODES-1:0] sel_o
);
    always_comb begin
        sel_o = '0;
        unique case (bilbo_mode_e'(mode_i))
            MODE_SCAN: sel_o[SEL_SCAN] = 1'b1;
            MODE_GEN:  sel_o[SEL_GEN]  = 1'b1;
            MODE_LOAD: sel_o[SEL_LOAD] = 1'b1;
            MODE_SIG:  sel_o[SEL_SIG]  = 1'b1;
            default:   sel_o = '0;
        endcase
    end
endmodule

// File: rtl/bilbo_feedback.sv
// Feedback bit for the polynomial 1 + x + x^N: last stage XOR first stage.
module bilbo_feedback (
    input  logic last_i,
    input  logic first_i,
    output logic fb_o
);
    always_comb fb_o = last_i ^ first_i;
endmodule

// File: rtl/bilbo_cell.sv
// Next value of one stage given the value arriving along the chain.
module bilbo_cell
    import bilbo_pkg::*;
(
    input  logic [NUM_MODES-1:0] sel_i,
    input  logic                 chain_i,
    input  logic                 data_i,
    output logic                 next_o
);
    always_comb begin
        next_o = ((sel_i[SEL_SCAN] | sel_i[SEL_GEN]) & chain_i)
               | (sel_i[SEL_LOAD] & data_i)
               | (sel_i[SEL_SIG]  & (chain_i ^ data_i));
    end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [1:0]   mode_i,
    input  logic [N-1:0] par_d_i,
    output logic [N-1:0] par_q_o,
    input  logic         scan_in_i,
    output logic         scan_out_o
);
    localparam int unsigned LAST = N - 1;

    typedef struct packed {
        logic [N-1:0] q;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_MODES-1:0] sel;
    logic                 fb;
    logic [N-1:0]         chain;
    logic [N-1:0]         cell_next;

    bilbo_mode_decode u_dec (
        .mode_i (mode_i),
        .sel_o  (sel)
    );

    bilbo_feedback u_fb (
        .last_i  (s_q.q[LAST]),
        .first_i (s_q.q[0]),
        .fb_o    (fb)
    );

    // value entering each stage along the chain
    always_comb begin
        chain[0] = sel[SEL_SCAN] ? scan_in_i : fb;
        for (int i = 1; i < N; i++) begin
            chain[i] = s_q.q[i-1];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cell
        bilbo_cell u_cell (
            .sel_i   (sel),
            .chain_i (chain[g]),
            .data_i  (par_d_i[g]),
            .next_o  (cell_next[g])
        );
    end

    always_comb begin
        s_d   = s_q;
        s_d.q = cell_next;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign par_q_o    = s_q.q;
    assign scan_out_o = s_q.q[LAST];

endmodule

// File: rtl/bilbo_checker.sv
module bilbo_checker #(
    parameter int unsigned N = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [1:0]   mode_i,
    input logic [N-1:0] par_d_i,
    input logic [N-1:0] par_q_o,
    input logic         scan_in_i,
    input logic         scan_out_o
);
    always_comb begin
        if (!rst_ni) assert_reset_zero_R1: assert (par_q_o == '0);
    end

    assert_scan_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b00) |=> (par_q_o == {$past(par_q_o[N-2:0]), $past(scan_in_i)}));

    assert_gen_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b01) |=>
        (par_q_o == {$past(par_q_o[N-2:0]), $past(par_q_o[N-1]) ^ $past(par_q_o[0])}));

    assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b10) |=> (par_q_o == $past(par_d_i)));

    assert_sig_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b11) |=>
        (par_q_o == ({$past(par_q_o[N-2:0]), $past(par_q_o[N-1]) ^ $past(par_q_o[0])}
                     ^ $past(par_d_i))));

    assert_scan_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scan_out_o == par_q_o[N-1]);
endmodule

bind bilbo_reg bilbo_checker #(.N(N)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .par_d_i    (par_d_i),
    .par_q_o    (par_q_o),
    .scan_in_i  (scan_in_i),
    .scan_out_o (scan_out_o)
);

// File: tb/sim_bilbo_reg.sv
`timescale 1ns/1ps
module sim_bilbo_reg;
    localparam int unsigned N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   mode;
    logic [N-1:0] d;
    logic [N-1:0] q;
    logic         si;
    logic         so;

    int errors = 0;
    int checks = 0;
    logic [N-1:0] model = '0;
    logic [1:0]   prev_mode = 2'b10;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    bilbo_reg #(.N(N)) u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mode_i     (mode),
        .par_d_i    (d),
        .par_q_o    (q),
        .scan_in_i  (si),
        .scan_out_o (so)
    );

    function automatic logic [N-1:0] step(logic [N-1:0] cur, logic [1:0] m,
                                          logic [N-1:0] din, logic sin);
        logic fbk;
        fbk = cur[N-1] ^ cur[0];
        case (m)
            2'b00:   return {cur[N-2:0], sin};
            2'b01:   return {cur[N-2:0], fbk};
            2'b10:   return din;
            default: return {cur[N-2:0], fbk} ^ din;
        endcase
    endfunction

    task automatic check(string req, logic [N-1:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%h expected %h", req, q, exp);
        end
        checks++;
        if (so !== exp[N-1]) begin
            errors++;
            $display("FAIL R6: scan_out=%b expected %b", so, exp[N-1]);
        end
    endtask

    function automatic string req_of(logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // one clock: drive at negedge, model at posedge, compare after it
    task automatic cycle(logic [1:0] m, logic [N-1:0] din, logic sin, string tag);
        @(negedge clk);
        mode = m; d = din; si = sin;
        @(posedge clk);
        model = step(model, m, din, sin);
        #2;
        check(tag == "" ? ((m != prev_mode) ? "R8" : req_of(m)) : tag, model);
        prev_mode = m;
    endtask

    initial begin
        rst_n = 1'b0; mode = 2'b10; d = 8'hA5; si = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;

        // normal load of several patterns
        cycle(2'b10, 8'h3C, 1'b0, "R4");
        cycle(2'b10, 8'hFF, 1'b0, "R4");
        cycle(2'b10, 8'h81, 1'b0, "R4");

        // scan shifting of an alternating pattern
        for (int i = 0; i < 12; i++) cycle(2'b00, 8'h00, i[0], "R2");

        // pattern generation from a seed, parallel input toggling
        cycle(2'b10, 8'h01, 1'b0, "R4");
        for (int i = 0; i < 40; i++) cycle(2'b01, $urandom, $urandom, "R9");
        for (int i = 0; i < 10; i++) cycle(2'b01, 8'h00, 1'b0, "R3");

        // signature compaction, then final signature
        cycle(2'b10, 8'h00, 1'b0, "R4");
        for (int i = 0; i < 50; i++) cycle(2'b11, $urandom, $urandom, "R5");

        // clear by shifting zeros from nonzero contents
        cycle(2'b10, 8'hFF, 1'b0, "R4");
        for (int i = 0; i < N; i++) cycle(2'b00, $urandom, 1'b0, "R2");
        check("R7", 8'h00);

        // random mode switching
        cycle(2'b10, 8'h5A, 1'b0, "R4");
        for (int i = 0; i < 300; i++) cycle($urandom, $urandom, $urandom, "");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule